// File: doc/BRIEF.md
# DMA Channel Register Bank with Interrupt Summary

This block holds the software-visible registers of a seven-channel DMA engine. A plain 32-bit word access port reaches one register per access. Every channel owns a base-address word, a block-count word and a control word. A shared group holds a priority/control word, an interrupt control word and two constant identification words. The address picks the group and the register within it. Writes are masked per register. Completion pulses from the transfer engine become sticky per-channel flags, and software clears them by writing ones.

The interrupt control word combines several write behaviours. It has plain read/write enables, a force bit, a master enable, write-one-to-clear flags and a read-only summary bit. The summary bit is evaluated on every change of its inputs. The interrupt request output is a single-cycle pulse, issued only when the summary bit changes from 0 to 1.

There is no stall: an access is taken in the cycle its strobe is high. Read data appears on `rd_data` one cycle later and holds until the next read.

Top module: `xfer_regbank`

## Requirements
- R1: A synchronous active-high reset clears every register, the read data output and the interrupt request to zero.
- R2: Address bits [6:4] select the group: values 0 to 6 select a channel and 7 selects the shared group. Address bits [3:2] select the register: for a channel, 0 is base address, 1 is block count and 2 is control. Read data is valid in the cycle after the read strobe.
- R3: A base-address write keeps only bits [23:0], with the upper bits reading zero. Block-count and channel-control writes store all 32 bits.
- R4: Channel register index 3 reads zero, and writes to it change nothing.
- R5: In the shared group, index 0 is a fully writable 32-bit word. Index 2 reads 0x7FFAC68B and index 3 reads 0x00FFFFF7. Writes to index 2 and index 3 are ignored.
- R6: In the interrupt control word (shared index 1), bits [5:0], bit 15 (force), bits [22:16] (per-channel enables, channel n at bit 16+n) and bit 23 (master enable) take the written value. Bits [14:6] always read zero.
- R7: Flag bits [30:24] (channel n at bit 24+n) are cleared by writing 1 to them. Writing 0 leaves them unchanged, and no write can set them.
- R8: A completion pulse on channel n sets flag n only if enable n is set in the stored word before that cycle. If a pulse and a write-one-to-clear hit the same flag in the same cycle, the flag ends up set.
- R9: Bit 31 reads 1 exactly when force is set, or when master enable is set and some channel has both its enable and its flag set. Bit 31 becomes visible in the same cycle as the change that causes it, and writes to bit 31 have no effect.
- R10: `irq_pulse` is high for exactly one cycle, in the first cycle bit 31 reads 1 after having read 0. While bit 31 stays at 1, no further pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access strobe, one access per cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 7 | Byte address; bits [6:2] are decoded |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, one cycle after the read strobe |
| done_pulse | input | 7 | Per-channel completion pulses |
| irq_pulse | output | 1 | Interrupt request pulse |

## Verification
Register writes take effect at the clock edge that samples the strobe. Interrupt-word flag and summary changes caused by a write or by a completion pulse are visible at that same edge. `irq_pulse` is high in the cycle that immediately follows that edge. Read data arrives one edge after the read strobe. The bench drives inputs on the falling edge and samples on the next falling edge, so each result is checked in exactly the cycle it is due. The single-cycle pulse width is confirmed by sampling again one cycle later.

// File: rtl/xfer_regbank_pkg.sv
package xfer_regbank_pkg;
  localparam int DW       = 32;
  localparam int CH_W     = 3;
  localparam int RG_W     = 2;
  localparam int MAX_CH   = 7;
  localparam logic [CH_W-1:0] SHARED_SEL = 3'd7;

  // register index inside a channel group
  localparam logic [RG_W-1:0] RG_BASE  = 2'd0;
  localparam logic [RG_W-1:0] RG_COUNT = 2'd1;
  localparam logic [RG_W-1:0] RG_CTRL  = 2'd2;

  // register index inside the shared group
  localparam logic [RG_W-1:0] RG_PRIO  = 2'd0;
  localparam logic [RG_W-1:0] RG_INTR  = 2'd1;
  localparam logic [RG_W-1:0] RG_IDA   = 2'd2;
  localparam logic [RG_W-1:0] RG_IDB   = 2'd3;

  localparam logic [DW-1:0] ID_WORD_A = 32'h7FFA_C68B;
  localparam logic [DW-1:0] ID_WORD_B = 32'h00FF_FFF7;

  // interrupt word field positions
  localparam int IW_LOW_W  = 6;
  localparam int IW_FORCE  = 15;
  localparam int IW_EN_LSB = 16;
  localparam int IW_MASTER = 23;
  localparam int IW_FL_LSB = 24;
  localparam int IW_SUM    = 31;
endpackage

// File: rtl/xfer_chan_regs.sv
module xfer_chan_regs
  import xfer_regbank_pkg::*;
#(
  parameter int BASE_W = 24
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [RG_W-1:0] rg_sel,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   base_word,
  output logic [DW-1:0]   count_word,
  output logic [DW-1:0]   ctrl_word
);
  logic [BASE_W-1:0] base_q;
  logic [DW-1:0]     count_q;
  logic [DW-1:0]     ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      count_q <= '0;
      ctrl_q  <= '0;
    end else if (we) begin
      case (rg_sel)
        RG_BASE:  base_q  <= wdata[BASE_W-1:0];
        RG_COUNT: count_q <= wdata;
        RG_CTRL:  ctrl_q  <= wdata;
        default:  ;
      endcase
    end
  end

  assign base_word  = {{(DW-BASE_W){1'b0}}, base_q};
  assign count_word = count_q;
  assign ctrl_word  = ctrl_q;
endmodule

// File: rtl/xfer_irq_ctrl.sv
module xfer_irq_ctrl
  import xfer_regbank_pkg::*;
#(
  parameter int NCH = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [DW-1:0]  wdata,
  input  logic [NCH-1:0] done,
  output logic [DW-1:0]  intr_word,
  output logic           irq
);
  localparam int PAD_EN = MAX_CH - NCH;

  logic [IW_LOW_W-1:0] low_q, low_n;
  logic                force_q, force_n;
  logic [NCH-1:0]      en_q, en_n;
  logic                master_q, master_n;
  logic [NCH-1:0]      flag_q, flag_n;
  logic                sum_q, sum_n;
  logic                irq_q;
  logic [NCH-1:0]      clr_bits;

  wire unused_wbits = ^{wdata[IW_FORCE-1:IW_LOW_W], wdata[IW_SUM]};

  always_comb begin
    low_n    = low_q;
    force_n  = force_q;
    en_n     = en_q;
    master_n = master_q;
    clr_bits = '0;
    if (we) begin
      low_n    = wdata[IW_LOW_W-1:0];
      force_n  = wdata[IW_FORCE];
      en_n     = wdata[IW_EN_LSB +: NCH];
      master_n = wdata[IW_MASTER];
      clr_bits = wdata[IW_FL_LSB +: NCH];
    end
    // a completion pulse gated by the stored enable beats a same-cycle clear
    flag_n = (flag_q & ~clr_bits) | (done & en_q);
    sum_n  = force_n | (master_n & |(en_n & flag_n));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      low_q    <= '0;
      force_q  <= 1'b0;
      en_q     <= '0;
      master_q <= 1'b0;
      flag_q   <= '0;
      sum_q    <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      low_q    <= low_n;
      force_q  <= force_n;
      en_q     <= en_n;
      master_q <= master_n;
      flag_q   <= flag_n;
      sum_q    <= sum_n;
      irq_q    <= sum_n & ~sum_q;
    end
  end

  generate
    if (PAD_EN > 0) begin : g_pad
      assign intr_word = {sum_q, {PAD_EN{1'b0}}, flag_q, master_q, {PAD_EN{1'b0}}, en_q,
                          force_q, {(IW_FORCE-IW_LOW_W){1'b0}}, low_q};
    end else begin : g_full
      assign intr_word = {sum_q, flag_q, master_q, en_q,
                          force_q, {(IW_FORCE-IW_LOW_W){1'b0}}, low_q};
    end
  endgenerate

  assign irq = irq_q;
endmodule

// File: rtl/xfer_regbank.sv
module xfer_regbank
  import xfer_regbank_pkg::*;
#(
  parameter int NCH    = 7,
  parameter int AW     = 7,
  parameter int BASE_W = 24
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           acc_en,
  input  logic           acc_wr,
  input  logic [AW-1:0]  acc_addr,
  input  logic [DW-1:0]  acc_wdata,
  output logic [DW-1:0]  rd_data,
  input  logic [NCH-1:0] done_pulse,
  output logic           irq_pulse
);
  logic [CH_W-1:0] grp;
  logic [RG_W-1:0] rg;
  logic            wr_acc;
  logic            rd_acc;

  assign grp    = acc_addr[6:4];
  assign rg     = acc_addr[3:2];
  assign wr_acc = acc_en & acc_wr;
  assign rd_acc = acc_en & ~acc_wr;

  wire unused_addr = ^acc_addr[1:0];

  logic [DW-1:0] base_a  [NCH];
  logic [DW-1:0] count_a [NCH];
  logic [DW-1:0] ctrl_a  [NCH];

  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_ch
      logic ch_we;
      assign ch_we = wr_acc && (grp == gi[CH_W-1:0]);
      xfer_chan_regs #(.BASE_W(BASE_W)) u_ch (
        .clk        (clk),
        .rst        (rst),
        .we         (ch_we),
        .rg_sel     (rg),
        .wdata      (acc_wdata),
        .base_word  (base_a[gi]),
        .count_word (count_a[gi]),
        .ctrl_word  (ctrl_a[gi])
      );
    end
  endgenerate

  logic [DW-1:0] prio_q;
  logic          shared_we;
  logic [DW-1:0] intr_word;

  assign shared_we = wr_acc && (grp == SHARED_SEL);

  always_ff @(posedge clk) begin
    if (rst)                             prio_q <= '0;
    else if (shared_we && rg == RG_PRIO) prio_q <= acc_wdata;
  end

  xfer_irq_ctrl #(.NCH(NCH)) u_irq (
    .clk       (clk),
    .rst       (rst),
    .we        (shared_we && rg == RG_INTR),
    .wdata     (acc_wdata),
    .done      (done_pulse),
    .intr_word (intr_word),
    .irq       (irq_pulse)
  );

  logic [DW-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (grp == SHARED_SEL) begin
      case (rg)
        RG_PRIO: rd_mux = prio_q;
        RG_INTR: rd_mux = intr_word;
        RG_IDA:  rd_mux = ID_WORD_A;
        default: rd_mux = ID_WORD_B;
      endcase
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (grp == i[CH_W-1:0]) begin
          case (rg)
            RG_BASE:  rd_mux = base_a[i];
            RG_COUNT: rd_mux = count_a[i];
            RG_CTRL:  rd_mux = ctrl_a[i];
            default:  rd_mux = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (rd_acc) rd_data <= rd_mux;
  end
endmodule

// File: rtl/xfer_regbank_chk.sv
module xfer_regbank_chk
  import xfer_regbank_pkg::*;
#(
  parameter int NCH = 7
) (
  input logic           clk,
  input logic           rst,
  input logic           acc_en,
  input logic           acc_wr,
  input logic [NCH-1:0] done_pulse,
  input logic [DW-1:0]  intr_word,
  input logic [DW-1:0]  rd_data,
  input logic           irq_pulse
);
  logic rst_seen = 1'b0;
  always_ff @(posedge clk) rst_seen <= rst;

  // R1: the cycle after a reset edge everything is quiet
  always_ff @(posedge clk) begin
    if (rst_seen) begin
      a_r1_quiet_after_reset: assert (!irq_pulse && rd_data == '0 && intr_word == '0);
    end
  end

  // R10: pulse lasts one cycle
  a_r10_one_cycle: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |=> !irq_pulse);

  // R10: pulse only after summary was low
  a_r10_needs_rise: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> (intr_word[IW_SUM] && !$past(intr_word[IW_SUM])));

  // R9/R10: every rise of the summary is announced
  a_r10_rise_announced: assert property (@(posedge clk) disable iff (rst)
    $rose(intr_word[IW_SUM]) |-> irq_pulse);

  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_fl
      // R8: a flag is set only by an enabled completion pulse
      a_r8_flag_set_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(intr_word[IW_FL_LSB+gi]) |->
          ($past(done_pulse[gi]) && $past(intr_word[IW_EN_LSB+gi])));
      // R7: a flag only falls through a write
      a_r7_flag_clear_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(intr_word[IW_FL_LSB+gi]) |-> $past(acc_en && acc_wr));
    end
  endgenerate
endmodule

bind xfer_regbank xfer_regbank_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .acc_en     (acc_en),
  .acc_wr     (acc_wr),
  .done_pulse (done_pulse),
  .intr_word  (intr_word),
  .rd_data    (rd_data),
  .irq_pulse  (irq_pulse)
);

// File: tb/test_xfer_regbank.sv
module test_xfer_regbank;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NCH = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_en = 1'b0;
  logic        acc_wr = 1'b0;
  logic [6:0]  acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] rd_data;
  logic [NCH-1:0] done_pulse = '0;
  logic        irq_pulse;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_regbank i_xfer_regbank (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_data(rd_data),
    .done_pulse(done_pulse), .irq_pulse(irq_pulse)
  );

  function automatic logic [6:0] adr(input int grp, input int rg);
    return 7'((grp << 4) | (rg << 2));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int grp, input int rg, input logic [31:0] d,
                    input logic [NCH-1:0] pulses = '0);
    acc_en = 1'b1; acc_wr = 1'b1; acc_addr = adr(grp, rg); acc_wdata = d;
    done_pulse = pulses;
    @(posedge clk); @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0; done_pulse = '0;
  endtask

  task automatic rd(input int grp, input int rg, output logic [31:0] d);
    acc_en = 1'b1; acc_wr = 1'b0; acc_addr = adr(grp, rg);
    @(posedge clk); @(negedge clk);
    acc_en = 1'b0;
    d = rd_data;
  endtask

  task automatic pulse(input logic [NCH-1:0] p);
    done_pulse = p;
    @(posedge clk); @(negedge clk);
    done_pulse = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", {31'b0, irq_pulse}, 32'h0);
    check("R1 rd_data", rd_data, 32'h0);
    rd(0, 0, d); check("R1 base0", d, 32'h0);
    rd(6, 2, d); check("R1 ctrl6", d, 32'h0);
    rd(7, 1, d); check("R1 intr", d, 32'h0);
  endtask

  task automatic t_channels();
    logic [31:0] d;
    for (int c = 0; c < NCH; c++) begin
      wr(c, 0, 32'hA500_0000 | 32'(c * 32'h0101_0101));
      wr(c, 1, 32'hF000_0000 + 32'(c));
      wr(c, 2, 32'h1234_0000 + 32'(c << 4));
    end
    for (int c = 0; c < NCH; c++) begin
      rd(c, 0, d); check("R3 base low 24 bits", d, (32'hA500_0000 | 32'(c * 32'h0101_0101)) & 32'h00FF_FFFF);
      rd(c, 1, d); check("R2 count", d, 32'hF000_0000 + 32'(c));
      rd(c, 2, d); check("R2 ctrl", d, 32'h1234_0000 + 32'(c << 4));
    end
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(3, 3, 32'hDEAD_BEEF);
    rd(3, 3, d); check("R4 idx3 reads zero", d, 32'h0);
    rd(3, 1, d); check("R4 neighbour kept", d, 32'hF000_0003);
  endtask

  task automatic t_shared();
    logic [31:0] d;
    wr(7, 0, 32'hCAFE_F00D);
    rd(7, 0, d); check("R5 prio", d, 32'hCAFE_F00D);
    wr(7, 2, 32'h0);
    wr(7, 3, 32'h0);
    rd(7, 2, d); check("R5 id A", d, 32'h7FFA_C68B);
    rd(7, 3, d); check("R5 id B", d, 32'h00FF_FFF7);
    rd(7, 1, d); check("R5 intr untouched", d, 32'h0);
  endtask

  task automatic t_intr_write();
    logic [31:0] d;
    wr(7, 1, 32'h7F7F_7FFF);
    rd(7, 1, d); check("R6 mask", d, 32'h007F_003F);
    wr(7, 1, 32'h8000_0000);
    rd(7, 1, d); check("R9 bit31 write ignored", d, 32'h0);
    check("R9 no irq", {31'b0, irq_pulse}, 32'h0);
  endtask

  task automatic t_flags();
    logic [31:0] d;
    wr(7, 1, 32'h0024_0000);          // enables ch2, ch5
    pulse(7'b000_1100);               // ch2 enabled, ch3 not
    rd(7, 1, d); check("R8 enabled flag only", d, 32'h0424_0000);
    wr(7, 1, 32'h0024_0000);
    rd(7, 1, d); check("R7 zero keeps flag", d, 32'h0424_0000);
    wr(7, 1, 32'h0424_0000);
    rd(7, 1, d); check("R7 one clears flag", d, 32'h0024_0000);
    pulse(7'b010_0000);
    wr(7, 1, 32'h2024_0000, 7'b010_0000);
    rd(7, 1, d); check("R8 set beats clear", d, 32'h2024_0000);
    wr(7, 1, 32'h2024_0000);
    rd(7, 1, d); check("R7 cleared", d, 32'h0024_0000);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    pulse(7'b010_0000);
    check("R9 master off no irq", {31'b0, irq_pulse}, 32'h0);
    wr(7, 1, 32'h00A4_0000);
    check("R10 pulse on rise", {31'b0, irq_pulse}, 32'h1);
    @(negedge clk);
    check("R10 pulse one cycle", {31'b0, irq_pulse}, 32'h0);
    rd(7, 1, d); check("R9 summary set", d, 32'hA0A4_0000);
    pulse(7'b000_0100);
    check("R10 no repeat while high", {31'b0, irq_pulse}, 32'h0);
    rd(7, 1, d); check("R9 two flags", d, 32'hA4A4_0000);
    wr(7, 1, 32'h24A4_0000);
    check("R10 no pulse on fall", {31'b0, irq_pulse}, 32'h0);
    rd(7, 1, d); check("R9 summary cleared", d, 32'h00A4_0000);
    wr(7, 1, 32'h0000_8000);
    check("R10 force pulse", {31'b0, irq_pulse}, 32'h1);
    rd(7, 1, d); check("R9 force summary", d, 32'h8000_8000);
    wr(7, 1, 32'h0);
    rd(7, 1, d); check("R9 force off", d, 32'h0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_channels();
    t_unmapped();
    t_shared();
    t_intr_write();
    t_flags();
    t_irq();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule